// File: doc/BRIEF.md
# Overlapping Coarse-Fine Code Reconstructor

A column-parallel converter with several staggered reference ramps delivers, for each sample, a small coarse code that names the ramp the comparator was attached to and a wider fine code measured along that ramp. Neighbouring ramps share a guard region, so a coarse decision that lands one ramp too high or too low still produces a usable fine code. This block turns each coarse/fine pair into one linear output word. It adds the ramp's starting level and subtracts the guard offset. It also clamps the result to the legal output range.

Each sample carries its own mode flag. In uniform mode every ramp has the same unit step and starts at coarse × 128, so no table is consulted. In companding mode each ramp has a programmable start level and a power-of-two step written as a shift. The fine code then has 64 levels plus a guard band, and the block scales it back with a shift and an add. Samples stream in with a valid flag and come out two clock cycles later in the same order.

Top module: `cf_recon_top`

## Requirements
- R1: After reset, out_valid is low and every ramp table entry holds start level k × 128 and shift 0 for ramp k.
- R2: Each accepted input (in_valid high) produces exactly one output with out_valid high two rising edges later. Order is kept, and cycles without input produce no output.
- R3: With in_mode = 0 (uniform), out_data = in_coarse × 128 + in_fine − 64, before clamping. The table contents have no effect.
- R4: A coarse code one ramp higher, with the fine code lowered by 128, gives the same output in uniform mode. A coarse error inside the guard band therefore leaves no gap.
- R5: With in_mode = 1 (companding), out_data = start[c] + (in_fine[6:0] − 32) × 2^shift[c], before clamping. Bit 7 of in_fine is ignored.
- R6: A result below zero is output as 0.
- R7: A result above 1023 is output as 1023.
- R8: A pulse on cfg_we writes cfg_base and cfg_shift into entry cfg_idx. The new entry applies to samples presented from the next cycle onward. A sample presented in the same cycle as the write uses the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Ramp entry to write |
| cfg_base | input | 10 | Start level of the ramp |
| cfg_shift | input | 2 | Log2 of the ramp step |
| in_valid | input | 1 | Sample present |
| in_mode | input | 1 | 0 = uniform ramps, 1 = companding |
| in_coarse | input | 3 | Ramp selected by the coarse pass |
| in_fine | input | 8 | Fine code along that ramp |
| out_valid | output | 1 | Linear result present |
| out_data | output | 10 | Linear result |

## Verification
The bench checks the guard band with pairs of inputs that describe the same level through two adjacent ramps. A design that concatenated the coarse and fine bits, or dropped the offset, would give the two members of a pair different values. Both clamp edges are driven: a negative sum from ramp 0 and an overshoot on the top ramps. A design that wrapped instead of clamping would output large values for the first and small values for the second. In companding mode the bench sets bit 7 of the fine code, so a design that failed to mask it would output a shifted result. A sample is also sent in the same cycle as a table write, which catches a table read that bypasses the write too early. Every output is checked for its exact cycle, so a missing or extra pipeline register shows up as a latency mismatch.

// File: rtl/cf_recon_pkg.sv
package cf_recon_pkg;

  // Start level plus a signed fine offset scaled by a power of two.
  function automatic int scale_add(input int base, input int diff, input int sh);
    return base + (diff <<< sh);
  endfunction

  // Clamp into [0, hi].
  function automatic int clamp_range(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/cf_recon_table.sv
module cf_recon_table #(
  parameter int CW  = 3,
  parameter int OW  = 10,
  parameter int SHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_idx,
  input  logic [OW-1:0]  wr_base,
  input  logic [SHW-1:0] wr_shift,
  input  logic [CW-1:0]  rd_idx,
  output logic [OW-1:0]  rd_base,
  output logic [SHW-1:0] rd_shift
);
  localparam int NRAMP = 1 << CW;

  logic [OW-1:0]  base_q  [NRAMP];
  logic [SHW-1:0] shift_q [NRAMP];

  for (genvar k = 0; k < NRAMP; k++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[k]  <= {CW'(k), {(OW-CW){1'b0}}};
        shift_q[k] <= '0;
      end else if (wr_en && wr_idx == CW'(k)) begin
        base_q[k]  <= wr_base;
        shift_q[k] <= wr_shift;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_shift = shift_q[rd_idx];

  // R8: a write lands in the addressed entry on the next edge
  p_table_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (shift_q[$past(wr_idx)] == $past(wr_shift)));
endmodule

// File: rtl/cf_recon_front.sv
module cf_recon_front #(
  parameter int CW      = 3,
  parameter int FW      = 8,
  parameter int OW      = 10,
  parameter int SHW     = 2,
  parameter int LIN_OVL = 64,
  parameter int CMP_FW  = 7,
  parameter int CMP_OVL = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_mode,
  input  logic [CW-1:0]       in_coarse,
  input  logic [FW-1:0]       in_fine,
  input  logic [OW-1:0]       tbl_base,
  input  logic [SHW-1:0]      tbl_shift,
  output logic                s1_valid,
  output logic [OW-1:0]       s1_base,
  output logic [SHW-1:0]      s1_shift,
  output logic signed [FW:0]  s1_diff
);
  int            lin_diff_i, cmp_diff_i;
  logic [OW-1:0] lin_base;

  always_comb begin
    lin_diff_i = int'(in_fine) - LIN_OVL;
    cmp_diff_i = int'(in_fine[CMP_FW-1:0]) - CMP_OVL;
  end
  assign lin_base = {in_coarse, {(OW-CW){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_base  <= '0;
      s1_shift <= '0;
      s1_diff  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        if (in_mode) begin
          s1_base  <= tbl_base;
          s1_shift <= tbl_shift;
          s1_diff  <= (FW+1)'(cmp_diff_i);
        end else begin
          s1_base  <= lin_base;
          s1_shift <= '0;
          s1_diff  <= (FW+1)'(lin_diff_i);
        end
      end
    end
  end

  // R2: stage one follows the input valid by one edge
  p_stage1_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(in_valid));

  // R3: uniform samples use unit step and ignore the table
  p_uniform_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode) |=> (s1_shift == '0));
endmodule

// File: rtl/cf_recon_back.sv
module cf_recon_back #(
  parameter int FW  = 8,
  parameter int OW  = 10,
  parameter int SHW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [OW-1:0]      s1_base,
  input  logic [SHW-1:0]     s1_shift,
  input  logic signed [FW:0] s1_diff,
  output logic               out_valid,
  output logic [OW-1:0]      out_data
);
  import cf_recon_pkg::*;

  localparam int FULL = (1 << OW) - 1;

  int   raw_sum, clamped;
  logic sat_lo, sat_hi;

  always_comb begin
    raw_sum = scale_add(int'(s1_base), int'(s1_diff), int'(s1_shift));
    clamped = clamp_range(raw_sum, FULL);
  end
  assign sat_lo = s1_valid && (raw_sum < 0);
  assign sat_hi = s1_valid && (raw_sum > FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= OW'(clamped);
    end
  end

  p_stage2_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));

  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo |=> (out_valid && out_data == '0));

  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi |=> (out_valid && out_data == OW'(FULL)));
endmodule

// File: rtl/cf_recon_top.sv
module cf_recon_top #(
  parameter int CW      = 3,
  parameter int FW      = 8,
  parameter int OW      = 10,
  parameter int SHW     = 2,
  parameter int LIN_OVL = 64,
  parameter int CMP_FW  = 7,
  parameter int CMP_OVL = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_idx,
  input  logic [OW-1:0]  cfg_base,
  input  logic [SHW-1:0] cfg_shift,
  input  logic           in_valid,
  input  logic           in_mode,
  input  logic [CW-1:0]  in_coarse,
  input  logic [FW-1:0]  in_fine,
  output logic           out_valid,
  output logic [OW-1:0]  out_data
);
  logic [OW-1:0]      tbl_base, s1_base;
  logic [SHW-1:0]     tbl_shift, s1_shift;
  logic               s1_valid;
  logic signed [FW:0] s1_diff;

  cf_recon_table #(.CW(CW), .OW(OW), .SHW(SHW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_shift(cfg_shift),
    .rd_idx(in_coarse), .rd_base(tbl_base), .rd_shift(tbl_shift)
  );

  cf_recon_front #(.CW(CW), .FW(FW), .OW(OW), .SHW(SHW), .LIN_OVL(LIN_OVL),
                   .CMP_FW(CMP_FW), .CMP_OVL(CMP_OVL)) u_front (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_mode(in_mode), .in_coarse(in_coarse), .in_fine(in_fine),
    .tbl_base(tbl_base), .tbl_shift(tbl_shift),
    .s1_valid(s1_valid), .s1_base(s1_base), .s1_shift(s1_shift), .s1_diff(s1_diff)
  );

  cf_recon_back #(.FW(FW), .OW(OW), .SHW(SHW)) u_back (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_base(s1_base), .s1_shift(s1_shift), .s1_diff(s1_diff),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R1: nothing leaves the block straight after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_cf_recon_top.sv
module tb_cf_recon_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [9:0] cfg_base = '0;
  logic [1:0] cfg_shift = '0;
  logic       in_valid = 1'b0;
  logic       in_mode = 1'b0;
  logic [2:0] in_coarse = '0;
  logic [7:0] in_fine = '0;
  logic       out_valid;
  logic [9:0] out_data;

  cf_recon_top dut (.*);

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int    exp_val[$];
  int    exp_cyc[$];
  string exp_tag[$];
  int    m_base[8];
  int    m_step[8];

  function automatic int model(input bit mode, input int c, input int f);
    int v;
    if (!mode) v = c * 128 + f - 64;
    else       v = m_base[c] + ((f % 128) - 32) * m_step[c];
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input bit mode, input int c, input int f);
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = 1'b1; in_mode = mode; in_coarse = 3'(c); in_fine = 8'(f);
    exp_val.push_back(model(mode, c, f));
    exp_cyc.push_back(cyc + 2);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0;
    end
  endtask

  task automatic write_entry(input int k, input int b, input int s, input bit with_sample,
                             input int f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(k); cfg_base = 10'(b); cfg_shift = 2'(s);
    if (with_sample) begin
      in_valid = 1'b1; in_mode = 1'b1; in_coarse = 3'(k); in_fine = 8'(f);
      exp_val.push_back(model(1'b1, k, f)); // R8: old entry applies
      exp_cyc.push_back(cyc + 2);
      exp_tag.push_back("R8");
    end else in_valid = 1'b0;
    m_base[k] = b;
    m_step[k] = 1 << s;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_val.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: unexpected output actual %0d expected none", out_data);
      end else begin
        check({exp_tag[0], " value"}, int'(out_data), exp_val[0]);
        check("R2 latency", cyc, exp_cyc[0]);
        void'(exp_val.pop_front()); void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int k = 0; k < 8; k++) begin m_base[k] = k * 128; m_step[k] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    // R1: reset table gives start k*128, unit step
    send("R1", 1'b1, 3, 40);
    // R3 uniform mode
    send("R3", 1'b0, 0, 64);
    send("R3", 1'b0, 3, 100);
    // R4 overlap pairs
    send("R4", 1'b0, 2, 228);
    send("R4", 1'b0, 4, 36);
    send("R4", 1'b0, 3, 164);
    // R6 / R7 clamps
    send("R6", 1'b0, 0, 0);
    send("R7", 1'b0, 7, 255);
    idle(2);
    // R5 bit 7 ignored in companding
    send("R5", 1'b1, 3, 168);
    idle(1);
    write_entry(5, 600, 2, 1'b0, 0);
    write_entry(6, 800, 3, 1'b0, 0);
    write_entry(1, 100, 1, 1'b0, 0);
    write_entry(0, 10, 3, 1'b0, 0);
    send("R5", 1'b1, 5, 0);
    send("R5", 1'b1, 5, 127);
    send("R5", 1'b1, 1, 0);
    send("R5", 1'b1, 5, 255);
    send("R7", 1'b1, 6, 127);
    send("R6", 1'b1, 0, 0);
    send("R3 table ignored", 1'b0, 5, 100);
    // R8 same-cycle write then next-cycle use
    write_entry(2, 900, 0, 1'b1, 32);
    send("R8", 1'b1, 2, 32);
    idle(3);
    // mixed stream with gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) send("R2 stream", lfsr[1], int'(lfsr[4:2]), int'(lfsr[12:5]));
      else idle(1);
    end
    idle(5);
    check("R2 all outputs seen", exp_val.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule